// File: doc/BRIEF.md
# Nickel Battery Charge Sequencer

This block steers one charge cycle of a nickel-chemistry pack. It reads the average cell voltage in millivolts and the pack temperature in tenths of a degree Celsius, along with a chemistry select (NiCd or NiMH), a battery-present flag, a one-minute tick and a programmed maximum fast-charge time counted in ticks. From these it chooses a charge-current level for an external regulator, reports its phase and raises a fault flag.

The cycle begins with a short conditioning phase at reduced current. Fast charge at full current follows and ends on whichever comes first: a fall of cell voltage from its running peak, a fast temperature rise between one-minute samples, or the timer running out, which counts as a fault. Thresholds depend on chemistry. A NiMH pack that starts fast charge with a low cell voltage ignores voltage fall during an early window and uses a stricter temperature-rate limit in that window. A NiMH charge ended by temperature rate after that window receives a low-current finishing phase. Afterwards the block waits with no current and starts again when the cell voltage sags. A temperature outside the allowed window pauses charging and freezes its timer. Pulling the battery returns the block to idle from anywhere.

Top module: `ni_charge_ctrl`

## Requirements
- R1: After reset the phase code is 0 (idle), the current code is 0 (off) and fault is low; with a battery present the block moves from idle to conditioning (phase 1) on the next clock.
- R2: In conditioning (phase 1) the current code is 2 (one-fifth); after tmax/12 in-range ticks it moves to fast charge (phase 2), recording whether cell voltage is below 1325 mV at that moment.
- R3: In fast charge the current code is 3 (full). If tmax in-range ticks pass with no termination, the phase becomes 5 (fault), fault goes high, the current code is 0, and it stays there while the battery remains.
- R4: For NiCd (chem_nimh=0), fast charge ends in the wait phase (4) when the running peak minus the present cell voltage reaches 20 mV, or when temperature has risen by at least 20 tenths since the previous tick's sample.
- R5: For NiMH whose cell voltage was below 1325 mV at fast-charge start, while fewer than tmax/12 fast ticks have elapsed a voltage fall is ignored and a rise of at least 15 tenths per tick ends fast charge in phase 4 (no finishing phase).
- R6: For NiMH outside that window, a 10 mV fall ends fast charge in phase 4, and a rise of at least 10 tenths per tick moves to the finishing phase (3); a NiCd charge never enters phase 3.
- R7: In the finishing phase (3) the current code is 1 (one-tenth); after tmax/3 in-range ticks it moves to phase 4.
- R8: Conditioning accepts temperature 50..450 tenths, fast charge and finishing accept 50..600; outside the window the current code is 0, ticks are not counted and no termination is taken, and charging resumes when it returns.
- R9: In the wait phase (4) the current code is 0; it moves to phase 1 only when cell voltage is below 1325 mV and temperature is within 50..450 tenths.
- R10: With the battery absent the phase becomes 0 on the next clock from any phase, clearing timers, the peak tracker and the early-window record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bat_present | input | 1 | Battery detected |
| chem_nimh | input | 1 | 1 = NiMH, 0 = NiCd |
| cell_mv | input | VW | Average cell voltage, mV |
| temp_dc | input | TMPW | Pack temperature, signed tenths of a degree C |
| min_tick | input | 1 | One-cycle pulse once a minute |
| tmax_ticks | input | TW | Maximum fast-charge time in ticks |
| i_lvl | output | 2 | Current code: 0 off, 1 tenth, 2 fifth, 3 full |
| chg_state | output | 3 | Phase: 0 idle, 1 condition, 2 fast, 3 finish, 4 wait, 5 fault |
| fault | output | 1 | High in the fault phase |

## Verification
Phase changes are registered, so the phase code moves one clock after the edge that sees the triggering tick, voltage fall or temperature sample, while the current code follows the phase code and the present temperature in the same cycle. The bench drives inputs after the falling edge, compares all three outputs against a behavioural model just after that, then advances the model at the rising edge, so every cycle is compared at the point where both have settled. Spot checks with fixed expected codes are placed right after the tick that is due to cause a phase change, and one tick before it, to pin the exact boundaries of tmax/12, tmax/3 and tmax.

// File: rtl/ni_chg_pkg.sv
package ni_chg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_COND  = 3'd1,
    PH_FAST  = 3'd2,
    PH_FIN   = 3'd3,
    PH_WAIT  = 3'd4,
    PH_FAULT = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    LVL_OFF   = 2'd0,
    LVL_TENTH = 2'd1,
    LVL_FIFTH = 2'd2,
    LVL_FULL  = 2'd3
  } lvl_t;
endpackage

// File: rtl/ni_chg_tick_cnt.sv
module ni_chg_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ni_chg_vpeak.sv
module ni_chg_vpeak #(
  parameter int VW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [VW-1:0] cell_mv,
  output logic [VW-1:0] drop_mv
);
  logic [VW-1:0] peak_q, peak_d;

  always_comb begin
    peak_d = peak_q;
    if (clr)                          peak_d = '0;
    else if (en && cell_mv > peak_q)  peak_d = cell_mv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) peak_q <= '0;
    else        peak_q <= peak_d;
  end

  assign drop_mv = (peak_q > cell_mv) ? (peak_q - cell_mv) : '0;

  // R4: the tracked peak never falls while tracking stays active
  p_peak_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en) |=> (peak_q >= $past(peak_q)));
endmodule

// File: rtl/ni_chg_trate.sv
module ni_chg_trate #(
  parameter int TMPW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   tick,
  input  logic signed [TMPW-1:0] temp_dc,
  output logic                   rate_vld,
  output logic signed [TMPW:0]   rate_dc
);
  logic signed [TMPW-1:0] prev_q, prev_d;
  logic                   have_q, have_d;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (clr) begin
      prev_d = '0;
      have_d = 1'b0;
    end else if (tick) begin
      prev_d = temp_dc;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

  assign rate_vld = tick && have_q && !clr;
  assign rate_dc  = (TMPW+1)'(temp_dc) - (TMPW+1)'(prev_q);
endmodule

// File: rtl/ni_charge_ctrl.sv
module ni_charge_ctrl
  import ni_chg_pkg::*;
#(
  parameter int TW         = 16,
  parameter int VW         = 13,
  parameter int TMPW       = 12,
  parameter int V_RESTART  = 1325,
  parameter int T_LO       = 50,
  parameter int T_HI_COND  = 450,
  parameter int T_HI_FAST  = 600,
  parameter int DROP_NICD  = 20,
  parameter int DROP_NIMH  = 10,
  parameter int RISE_NICD  = 20,
  parameter int RISE_EARLY = 15,
  parameter int RISE_NIMH  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bat_present,
  input  logic                   chem_nimh,
  input  logic [VW-1:0]          cell_mv,
  input  logic signed [TMPW-1:0] temp_dc,
  input  logic                   min_tick,
  input  logic [TW-1:0]          tmax_ticks,
  output logic [1:0]             i_lvl,
  output logic [2:0]             chg_state,
  output logic                   fault
);
  localparam logic [VW-1:0] VLOW = VW'(V_RESTART);
  localparam logic signed [TMPW:0] R_NICD  = (TMPW+1)'(RISE_NICD);
  localparam logic signed [TMPW:0] R_EARLY = (TMPW+1)'(RISE_EARLY);
  localparam logic signed [TMPW:0] R_NIMH  = (TMPW+1)'(RISE_NIMH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  phase_t        ph_q, ph_d;
  logic          early_q, early_d;
  logic [TW-1:0] tmr;
  logic [TW:0]   tmr_nx;
  logic [TW-1:0] t_cond, t_fin;
  logic          ok_cond, ok_fast, tmr_en, tmr_clr;
  logic          holdoff, v_term, r_term;
  logic [VW-1:0] drop_mv, drop_thr;
  logic          rate_vld;
  logic signed [TMPW:0] rate_dc, rise_thr;

  assign t_cond  = tmax_ticks / TW'(12);
  assign t_fin   = tmax_ticks / TW'(3);
  assign tmr_nx  = {1'b0, tmr} + (TW+1)'(1);
  assign ok_cond = (temp_dc >= T_LO) && (temp_dc <= T_HI_COND);
  assign ok_fast = (temp_dc >= T_LO) && (temp_dc <= T_HI_FAST);

  always_comb begin
    tmr_en = 1'b0;
    unique case (ph_q)
      PH_COND:        tmr_en = min_tick && ok_cond;
      PH_FAST, PH_FIN: tmr_en = min_tick && ok_fast;
      default:        tmr_en = 1'b0;
    endcase
  end

  ni_chg_tick_cnt #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_s), .clr(tmr_clr), .en(tmr_en), .cnt(tmr)
  );

  ni_chg_vpeak #(.VW(VW)) u_peak (
    .clk(clk), .rst_n(rst_s), .clr(ph_q != PH_FAST), .en(1'b1),
    .cell_mv(cell_mv), .drop_mv(drop_mv)
  );

  ni_chg_trate #(.TMPW(TMPW)) u_rate (
    .clk(clk), .rst_n(rst_s), .clr(ph_q != PH_FAST), .tick(min_tick),
    .temp_dc(temp_dc), .rate_vld(rate_vld), .rate_dc(rate_dc)
  );

  // termination criteria by chemistry and early window
  assign holdoff  = chem_nimh && early_q && (tmr < t_cond);
  assign drop_thr = chem_nimh ? VW'(DROP_NIMH) : VW'(DROP_NICD);
  always_comb begin
    if (!chem_nimh)   rise_thr = R_NICD;
    else if (holdoff) rise_thr = R_EARLY;
    else              rise_thr = R_NIMH;
  end
  assign v_term = ok_fast && !holdoff && (drop_mv >= drop_thr);
  assign r_term = ok_fast && rate_vld && (rate_dc >= rise_thr);

  always_comb begin
    ph_d    = ph_q;
    early_d = early_q;
    if (!bat_present) begin
      ph_d    = PH_IDLE;
      early_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: ph_d = PH_COND;
        PH_COND: if (tmr_en && tmr_nx >= {1'b0, t_cond}) begin
          ph_d    = PH_FAST;
          early_d = cell_mv < VLOW;
        end
        PH_FAST: begin
          if (v_term)      ph_d = PH_WAIT;
          else if (r_term) ph_d = (chem_nimh && !holdoff) ? PH_FIN : PH_WAIT;
          else if (tmr_en && tmr_nx >= {1'b0, tmax_ticks}) ph_d = PH_FAULT;
        end
        PH_FIN:  if (tmr_en && tmr_nx >= {1'b0, t_fin}) ph_d = PH_WAIT;
        PH_WAIT: if ((cell_mv < VLOW) && ok_cond) ph_d = PH_COND;
        default: ph_d = ph_q;
      endcase
    end
  end

  assign tmr_clr = (ph_d != ph_q) || !bat_present;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ph_q    <= PH_IDLE;
      early_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      early_q <= early_d;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_COND: i_lvl = ok_cond ? LVL_FIFTH : LVL_OFF;
      PH_FAST: i_lvl = ok_fast ? LVL_FULL  : LVL_OFF;
      PH_FIN:  i_lvl = ok_fast ? LVL_TENTH : LVL_OFF;
      default: i_lvl = LVL_OFF;
    endcase
  end

  assign chg_state = ph_q;
  assign fault     = (ph_q == PH_FAULT);

  p_unplug_idle_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !bat_present |=> (chg_state == PH_IDLE));
  p_fault_sticky_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (fault && bat_present) |=> fault);
  p_nicd_no_fin_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (ph_q == PH_FAST && !chem_nimh) |=> (ph_q != PH_FIN));
  p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (ph_q == PH_FAST && bat_present && !ok_fast) |=> (ph_q == PH_FAST && $stable(tmr)));
  p_cond_exit_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (ph_q == PH_COND && bat_present) |=> (ph_q == PH_COND || ph_q == PH_FAST));
endmodule

// File: tb/ni_charge_ctrl_tb_top.sv
module ni_charge_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMAX = 24;

  logic clk, rst_n, bat_present, chem_nimh, min_tick;
  logic [12:0] cell_mv;
  logic signed [11:0] temp_dc;
  logic [15:0] tmax_ticks;
  logic [1:0] i_lvl;
  logic [2:0] chg_state;
  logic fault;

  int n_vec, n_bad;
  string cur_req;

  // behavioural model state
  int m_ph, m_tmr, m_peak, m_prev, m_early;
  bit m_have;

  ni_charge_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bat_present(bat_present), .chem_nimh(chem_nimh),
    .cell_mv(cell_mv), .temp_dc(temp_dc), .min_tick(min_tick),
    .tmax_ticks(tmax_ticks), .i_lvl(i_lvl), .chg_state(chg_state), .fault(fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int m_lvl();
    int t = int'(temp_dc);
    bit okc = (t >= 50) && (t <= 450);
    bit okf = (t >= 50) && (t <= 600);
    case (m_ph)
      1: return okc ? 2 : 0;
      2: return okf ? 3 : 0;
      3: return okf ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int t = int'(temp_dc);
    int c = int'(cell_mv);
    bit okc = (t >= 50) && (t <= 450);
    bit okf = (t >= 50) && (t <= 600);
    int tc = TMAX / 12, tf = TMAX / 3;
    int nph = m_ph;
    bit hold, tk = min_tick;
    int drop, vthr, rthr, rate;
    if (!bat_present) begin
      m_ph = 0; m_tmr = 0; m_peak = 0; m_have = 0; m_early = 0;
      return;
    end
    case (m_ph)
      0: nph = 1;
      1: if (tk && okc) begin
           if (m_tmr + 1 >= tc) begin nph = 2; m_early = (c < 1325); end
           else m_tmr++;
         end
      2: begin
           hold = chem_nimh && m_early && (m_tmr < tc);
           drop = (m_peak > c) ? m_peak - c : 0;
           vthr = chem_nimh ? 10 : 20;
           rthr = !chem_nimh ? 20 : (hold ? 15 : 10);
           rate = t - m_prev;
           if (okf && !hold && drop >= vthr) nph = 4;
           else if (okf && tk && m_have && rate >= rthr) nph = (chem_nimh && !hold) ? 3 : 4;
           else if (okf && tk) begin
             if (m_tmr + 1 >= TMAX) nph = 5; else m_tmr++;
           end
           if (c > m_peak) m_peak = c;
           if (tk) begin m_prev = t; m_have = 1; end
         end
      3: if (tk && okf) begin
           if (m_tmr + 1 >= tf) nph = 4; else m_tmr++;
         end
      4: if (c < 1325 && okc) nph = 1;
      default: ;
    endcase
    if (nph != m_ph) m_tmr = 0;
    if (nph != 2) begin m_peak = 0; m_have = 0; m_prev = 0; end
    if (nph == 0) m_early = 0;
    m_ph = nph;
  endtask

  task automatic cmp(string what, int act, int exp, string req);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: inputs already set at negedge; compare, then advance
  task automatic cyc(bit tk);
    min_tick = tk;
    #1;
    cmp("state-vs-model", int'(chg_state), m_ph, cur_req);
    cmp("level-vs-model", int'(i_lvl), m_lvl(), cur_req);
    cmp("fault-vs-model", int'(fault), (m_ph == 5) ? 1 : 0, cur_req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    min_tick = 1'b0;
  endtask

  task automatic spot(int ph, int lvl, string req);
    #1;
    cmp("state", int'(chg_state), ph, req);
    cmp("level", int'(i_lvl), lvl, req);
  endtask

  task automatic unplug();
    cur_req = "R10";
    bat_present = 1'b0;
    cyc(0); cyc(0);
    spot(0, 0, "R10");
    cmp("fault", int'(fault), 0, "R10");
  endtask

  // from idle: enter conditioning and run two ticks into fast charge
  task automatic to_fast();
    bat_present = 1'b1;
    cyc(0);
    spot(1, 2, "R2");
    cyc(1);
    spot(1, 2, "R2");
    cyc(1);
    spot(2, 3, "R2");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0; cur_req = "R1";
    m_ph = 0; m_tmr = 0; m_peak = 0; m_prev = 0; m_early = 0; m_have = 0;
    rst_n = 1'b0; bat_present = 1'b0; chem_nimh = 1'b0; min_tick = 1'b0;
    cell_mv = 13'd1200; temp_dc = 12'sd250; tmax_ticks = 16'(TMAX);
    repeat (3) @(negedge clk);
    spot(0, 0, "R1");
    cmp("fault", int'(fault), 0, "R1");
    rst_n = 1'b1;
    repeat (4) cyc(0);
    spot(0, 0, "R1");

    // NiCd voltage fall, then recharge wait
    cur_req = "R4";
    to_fast();
    cell_mv = 13'd1450; cyc(0); cyc(0);
    cell_mv = 13'd1435; cyc(0);
    spot(2, 3, "R4");
    cell_mv = 13'd1430; cyc(0);
    spot(4, 0, "R4");
    cur_req = "R9";
    cell_mv = 13'd1400; repeat (3) cyc(1);
    spot(4, 0, "R9");
    cell_mv = 13'd1300; temp_dc = 12'sd500; repeat (3) cyc(0);
    spot(4, 0, "R9");
    temp_dc = 12'sd250; cyc(0);
    spot(1, 2, "R9");
    unplug();

    // NiCd temperature rate
    cur_req = "R4";
    cell_mv = 13'd1200; temp_dc = 12'sd250;
    to_fast();
    cyc(1);
    temp_dc = 12'sd269; cyc(1);
    spot(2, 3, "R4");
    temp_dc = 12'sd289; cyc(1);
    spot(4, 0, "R4");
    unplug();

    // NiMH early window
    cur_req = "R5";
    chem_nimh = 1'b1; cell_mv = 13'd1200; temp_dc = 12'sd250;
    to_fast();
    cyc(1);
    cell_mv = 13'd1400; cyc(0);
    cell_mv = 13'd1380; cyc(0); cyc(0);
    spot(2, 3, "R5");
    cell_mv = 13'd1400;
    temp_dc = 12'sd265; cyc(1);
    spot(4, 0, "R5");
    unplug();

    // NiMH late temperature rate and finishing phase
    cur_req = "R6";
    cell_mv = 13'd1400; temp_dc = 12'sd250;
    to_fast();
    cyc(1);
    temp_dc = 12'sd260; cyc(1);
    spot(3, 1, "R6");
    cur_req = "R7";
    repeat (7) cyc(1);
    spot(3, 1, "R7");
    cyc(1);
    spot(4, 0, "R7");
    unplug();

    // NiMH voltage fall
    cur_req = "R6";
    cell_mv = 13'd1400; temp_dc = 12'sd250;
    to_fast();
    cyc(0);
    cell_mv = 13'd1391; cyc(0);
    spot(2, 3, "R6");
    cell_mv = 13'd1390; cyc(0);
    spot(4, 0, "R6");
    unplug();

    // temperature pause in conditioning and fast charge
    cur_req = "R8";
    cell_mv = 13'd1400; temp_dc = 12'sd250; bat_present = 1'b1;
    cyc(0);
    temp_dc = 12'sd500;
    spot(1, 0, "R8");
    repeat (3) cyc(1);
    spot(1, 0, "R8");
    temp_dc = 12'sd40; cyc(1);
    spot(1, 0, "R8");
    temp_dc = 12'sd250; cyc(1);
    spot(1, 2, "R8");
    cyc(1);
    spot(2, 3, "R8");
    temp_dc = 12'sd650;
    spot(2, 0, "R8");
    cell_mv = 13'd1300; repeat (4) cyc(1);
    spot(2, 0, "R8");
    cell_mv = 13'd1400; temp_dc = 12'sd250; cyc(0);
    spot(2, 3, "R8");

    // timer expiry into fault (continues same fast charge, 0 ticks counted)
    cur_req = "R3";
    repeat (23) cyc(1);
    spot(2, 3, "R3");
    cyc(1);
    spot(5, 0, "R3");
    cmp("fault", int'(fault), 1, "R3");
    cell_mv = 13'd1300; repeat (3) cyc(1);
    spot(5, 0, "R3");
    unplug();

    finish_run();
  end
endmodule